// File: doc/BRIEF.md
# Command-Queue I2C Bus Master

This block is an I2C/SMBus bus master that software drives through a small 32-bit register port. Software does not strobe bus conditions one at a time. It queues command words. Each word carries one byte plus three flags: a START before the byte, a STOP after it, and a read of N bytes. A sequencer takes words from a transmit queue one at a time. It turns them into bus activity on open-drain style SCL and SDA pull-down outputs. Bytes read from the slave go into a receive queue.

A status word reports three things: a finished transaction, a slave NACK and a dropped push. A mask word with the same bit positions routes any of these to an interrupt line. A control word holds the enable and the SCL divider, and carries self-clearing flush strobes for both queues. After a NACK, the sequencer closes the bus with a STOP. It then discards the rest of that transaction, so that the next queued transaction starts clean.

Top module: `cmdq_i2c_master`

## Requirements
- R1: After reset the status reads 0, irq is low, both bus outputs are released (scl_pull and sda_pull are 0), the control word reads 0 and the revision word reads the REV_ID parameter.
- R2: A word with bit 8 set produces a START: SDA falls while SCL is high. The byte in bits [7:0] is then sent MSB first, with SCL high for each bit, and the master releases SDA during the ninth (acknowledge) clock.
- R3: Transmit words use bits [7:0] for data, bit 8 for START, bit 9 for STOP after the byte and bit 10 for read. A STOP is SDA rising while SCL is high.
- R4: With bit 10 set, bits [7:0] give the read count. The master ACKs every received byte except the last byte of a STOP-flagged read, which it NACKs. The bytes enter the receive queue in order.
- R5: A read at offset 0x04 returns the oldest received byte in bits [7:0] and pops it. Bit 8 reads 1 when the queue is empty, and nothing is popped in that case.
- R6: A START-flagged word that follows bytes sent without a STOP produces a repeated START, with no STOP in between.
- R7: Status bit 27 sets when a sequence ending in STOP completes, and the bus is released at that time. Writing 1 to bit 27 clears it.
- R8: A slave NACK of a sent byte sets status bit 21. The master then issues a STOP and discards the queued words up to and including the next STOP-flagged word. It then sets bit 27, and the following transactions run normally.
- R9: The mask word (offset 0x18) uses the status bit positions. irq is high exactly while some status bit and its mask bit are both 1, so a zero mask forces irq low.
- R10: In the control word (0x1C), bit 9 written as 1 flushes the transmit queue and bit 10 flushes the receive queue. Bit 11 enables command execution; while it is 0, queued words wait and the bus stays idle. Bits [7:0] (div) set each SCL low or high half-period to (div+1)*4 clocks.
- R11: A push to a full transmit queue (DEPTH words) is dropped and sets status bit 0, which is cleared by writing 1 to it.
- R12: Offsets: transmit queue 0x00, receive queue 0x04, status 0x14, mask 0x18, control 0x1C, revision 0x28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at offset 0x04) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sampled SDA line level |
| irq | output | 1 | Masked status interrupt |

## Verification
Register writes take effect at the next clock edge. Read data is combinational and valid in the cycle of the strobe, so the bench samples it one nanosecond after driving the strobe at a falling edge. Bus activity moves in half-periods of (div+1)*4 clocks, and a slave model samples SCL and SDA once per clock. The model therefore counts START and STOP conditions, acknowledge levels and the shortest SCL-high run exactly, and the width checks expect one half-period. Status bit 27 rises only at the end of the final STOP half-period, or when the discard of a NACKed transaction completes. The bench therefore polls the status word for completion, with a bound on the number of polls, and does not use fixed delays. Checks for ignored or discarded activity wait several hundred clocks and then compare the slave's counters and memory.

// File: rtl/cmdq_i2c_master.sv
`timescale 1ns/1ps
module cmdq_i2c_master #(
  parameter int          DEPTH  = 16,
  parameter logic [31:0] REV_ID = 32'h0000_0106
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        scl_pull,
  output logic        sda_pull,
  input  logic        sda_in,
  output logic        irq
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = 11;
  localparam int DW   = 8;
  localparam int CNTW = DW + 2;

  localparam int W_START = 8;
  localparam int W_STOP  = 9;
  localparam int W_READ  = 10;
  localparam int B_OVF   = 0;
  localparam int B_NACK  = 21;
  localparam int B_DONE  = 27;
  localparam int C_TXCLR = 9;
  localparam int C_RXCLR = 10;
  localparam int C_EN    = 11;

  localparam logic [7:0] A_TX  = 8'h00;
  localparam logic [7:0] A_RX  = 8'h04;
  localparam logic [7:0] A_STS = 8'h14;
  localparam logic [7:0] A_MSK = 8'h18;
  localparam logic [7:0] A_CTL = 8'h1C;
  localparam logic [7:0] A_REV = 8'h28;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_FALL, S_BLO, S_BHI, S_ALO, S_AHI, S_PLO, S_PHI, S_PEND
  } seq_t;

  // register decode
  logic tx_wr, ctl_wr, sts_wr, msk_wr, rx_rd;
  assign tx_wr  = bus_wr && bus_addr == A_TX;
  assign ctl_wr = bus_wr && bus_addr == A_CTL;
  assign sts_wr = bus_wr && bus_addr == A_STS;
  assign msk_wr = bus_wr && bus_addr == A_MSK;
  assign rx_rd  = bus_rd && bus_addr == A_RX;

  logic          en;
  logic [DW-1:0] div;
  logic [31:0]   msk;
  logic          tx_flush, rx_flush;
  assign tx_flush = ctl_wr && bus_wdata[C_TXCLR];
  assign rx_flush = ctl_wr && bus_wdata[C_RXCLR];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en  <= 1'b0;
      div <= '0;
      msk <= '0;
    end else begin
      if (ctl_wr) begin
        en  <= bus_wdata[C_EN];
        div <= bus_wdata[DW-1:0];
      end
      if (msk_wr) msk <= bus_wdata;
    end

  // transmit queue
  logic [CW-1:0] txm [DEPTH];
  logic [AW:0]   txw, txr;
  logic          tx_empty, tx_full, tx_push, tx_pop;
  logic [CW-1:0] tx_head;
  assign tx_empty = txw == txr;
  assign tx_full  = (txw[AW] != txr[AW]) && (txw[AW-1:0] == txr[AW-1:0]);
  assign tx_push  = tx_wr && !tx_full;
  assign tx_head  = txm[txr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      txw <= '0;
      txr <= '0;
    end else if (tx_flush) begin
      txw <= '0;
      txr <= '0;
    end else begin
      if (tx_push) txw <= txw + 1'b1;
      if (tx_pop)  txr <= txr + 1'b1;
    end

  always_ff @(posedge clk)
    if (tx_push) txm[txw[AW-1:0]] <= bus_wdata[CW-1:0];

  // receive queue
  logic [DW-1:0] rxm [DEPTH];
  logic [AW:0]   rxw, rxr;
  logic          rx_empty, rx_full, rx_push, rx_pop, rx_push_req;
  assign rx_empty = rxw == rxr;
  assign rx_full  = (rxw[AW] != rxr[AW]) && (rxw[AW-1:0] == rxr[AW-1:0]);
  assign rx_push  = rx_push_req && !rx_full;
  assign rx_pop   = rx_rd && !rx_empty;

  logic [DW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rxw <= '0;
      rxr <= '0;
    end else if (rx_flush) begin
      rxw <= '0;
      rxr <= '0;
    end else begin
      if (rx_push) rxw <= rxw + 1'b1;
      if (rx_pop)  rxr <= rxr + 1'b1;
    end

  always_ff @(posedge clk)
    if (rx_push) rxm[rxw[AW-1:0]] <= sh;

  // bus sequencer
  seq_t            st;
  logic [CNTW-1:0] cnt;
  logic [2:0]      bitn;
  logic [DW-1:0]   rdn;
  logic            rd_f, stop_f, owned, skip, nacked;
  logic            tick, fetch, set_done, set_nack;

  assign tick        = cnt == {div, 2'b11};
  assign fetch       = st == S_IDLE && en && !tx_empty;
  assign tx_pop      = fetch;
  assign rx_push_req = st == S_AHI && tick && rd_f;
  assign set_nack    = st == S_AHI && tick && !rd_f && sda_in;
  assign set_done    = (st == S_PEND && tick && !(nacked && !stop_f))
                    || (fetch && skip && tx_head[W_STOP]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (st == S_IDLE || tick) cnt <= '0;
    else cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      bitn   <= '0;
      sh     <= '0;
      rdn    <= '0;
      rd_f   <= 1'b0;
      stop_f <= 1'b0;
      owned  <= 1'b0;
      skip   <= 1'b0;
      nacked <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (fetch) begin
          if (skip) begin
            if (tx_head[W_STOP]) skip <= 1'b0;
          end else begin
            stop_f <= tx_head[W_STOP];
            rd_f   <= tx_head[W_READ];
            bitn   <= 3'd7;
            if (tx_head[W_READ]) begin
              rdn <= tx_head[DW-1:0];
              sh  <= '0;
              if (tx_head[DW-1:0] != '0)            st <= S_BLO;
              else if (tx_head[W_STOP] && owned)    st <= S_PLO;
            end else begin
              sh <= tx_head[DW-1:0];
              st <= (tx_head[W_START] || !owned) ? S_PRE : S_BLO;
            end
          end
        end
        S_PRE:  if (tick) st <= S_FALL;
        S_FALL: if (tick) begin
          st    <= S_BLO;
          owned <= 1'b1;
        end
        S_BLO:  if (tick) st <= S_BHI;
        S_BHI:  if (tick) begin
          sh <= {sh[DW-2:0], sda_in};
          if (bitn == 3'd0) st <= S_ALO;
          else begin
            bitn <= bitn - 1'b1;
            st   <= S_BLO;
          end
        end
        S_ALO:  if (tick) st <= S_AHI;
        S_AHI:  if (tick) begin
          bitn <= 3'd7;
          if (rd_f) begin
            rdn <= rdn - 1'b1;
            if (rdn == 8'd1) st <= stop_f ? S_PLO : S_IDLE;
            else             st <= S_BLO;
          end else if (sda_in) begin
            nacked <= 1'b1;
            st     <= S_PLO;
          end else begin
            st <= stop_f ? S_PLO : S_IDLE;
          end
        end
        S_PLO:  if (tick) st <= S_PHI;
        S_PHI:  if (tick) st <= S_PEND;
        S_PEND: if (tick) begin
          st     <= S_IDLE;
          owned  <= 1'b0;
          nacked <= 1'b0;
          if (nacked && !stop_f) skip <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
      if (tx_flush) skip <= 1'b0;
    end

  always_comb
    case (st)
      S_IDLE:                     scl_pull = owned;
      S_BLO, S_ALO, S_PLO:        scl_pull = 1'b1;
      default:                    scl_pull = 1'b0;
    endcase

  always_comb
    case (st)
      S_FALL, S_PLO, S_PHI:       sda_pull = 1'b1;
      S_BLO, S_BHI:               sda_pull = !rd_f && !sh[DW-1];
      S_ALO, S_AHI:               sda_pull = rd_f && !(rdn == 8'd1 && stop_f);
      default:                    sda_pull = 1'b0;
    endcase

  // status
  logic sts_done, sts_nack, sts_ovf;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sts_done <= 1'b0;
      sts_nack <= 1'b0;
      sts_ovf  <= 1'b0;
    end else begin
      if (set_done) sts_done <= 1'b1;
      else if (sts_wr && bus_wdata[B_DONE]) sts_done <= 1'b0;
      if (set_nack) sts_nack <= 1'b1;
      else if (sts_wr && bus_wdata[B_NACK]) sts_nack <= 1'b0;
      if (tx_wr && tx_full) sts_ovf <= 1'b1;
      else if (sts_wr && bus_wdata[B_OVF]) sts_ovf <= 1'b0;
    end

  logic [31:0] sts_vec;
  always_comb begin
    sts_vec         = '0;
    sts_vec[B_DONE] = sts_done;
    sts_vec[B_NACK] = sts_nack;
    sts_vec[B_OVF]  = sts_ovf;
  end

  assign irq = |(sts_vec & msk);

  always_comb
    case (bus_addr)
      A_RX:    bus_rdata = {23'b0, rx_empty, rx_empty ? 8'h00 : rxm[rxr[AW-1:0]]};
      A_STS:   bus_rdata = sts_vec;
      A_MSK:   bus_rdata = msk;
      A_CTL:   bus_rdata = {20'b0, en, 3'b000, div};
      A_REV:   bus_rdata = REV_ID;
      default: bus_rdata = '0;
    endcase

  // R11
  ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_full) |=> sts_ovf);

  // R2
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull && $past(!scl_pull) && !$stable(sda_pull)) |-> (st == S_FALL || st == S_PEND));

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_wr && bus_wdata == 32'h0) |=> !irq);

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[C_TXCLR] && bus_wdata[C_RXCLR]) |=> (tx_empty && rx_empty));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_done) |-> (!scl_pull && !sda_pull));
endmodule

// File: tb/cmdq_i2c_master_tb_top.sv
`timescale 1ns/1ps
module cmdq_i2c_master_tb_top;
  localparam logic [31:0] REV = 32'h0000_0106;
  localparam logic [7:0] A_TX = 8'h00, A_RX = 8'h04, A_STS = 8'h14,
                         A_MSK = 8'h18, A_CTL = 8'h1C, A_REV = 8'h28;
  localparam logic [31:0] F_START = 32'h100, F_STOP = 32'h200, F_READ = 32'h400;
  localparam logic [31:0] C_EN = 32'h800, C_TXCLR = 32'h200, C_RXCLR = 32'h400;
  localparam logic [31:0] ST_DONE = 32'h0800_0000, ST_NACK = 32'h0020_0000, ST_OVF = 32'h1;
  localparam logic [6:0] SADDR = 7'h50;
  localparam int SI = 0, SA = 1, SW = 2, SAA = 3, SAD = 4, STX = 5, SM = 6, SG = 7;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        scl_pull, sda_pull, irq;
  logic        s_pull;
  logic        hi_clr = 1'b0;
  logic        scl_l, sda_l;
  assign scl_l = !scl_pull;
  assign sda_l = !(sda_pull || s_pull);

  cmdq_i2c_master #(.DEPTH(16), .REV_ID(REV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda_l), .irq(irq));

  // slave model sampled once per clock
  logic       ps, pd, srw, sfirst, smack;
  logic [7:0] ssh, stxb;
  logic [7:0] smem [16];
  logic [3:0] sptr;
  int sst, sbc, n_start, n_stop, n_mack, n_mnack, hi_run, hi_min;

  always @(posedge clk) begin
    if (!rst_n) begin
      ps <= 1'b1; pd <= 1'b1; s_pull <= 1'b0; sst <= SI; sbc <= 0;
      ssh <= 8'h0; stxb <= 8'h0; sptr <= 4'h0; srw <= 1'b0; sfirst <= 1'b0;
      smack <= 1'b0; n_start <= 0; n_stop <= 0; n_mack <= 0; n_mnack <= 0;
      hi_run <= 0; hi_min <= 99999;
      for (int i = 0; i < 16; i++) smem[i] <= 8'h00;
    end else begin
      ps <= scl_l;
      pd <= sda_l;
      hi_run <= scl_l ? (ps ? hi_run + 1 : 1) : 0;
      if (hi_clr) hi_min <= 99999;
      else if (ps && !scl_l && hi_run < hi_min) hi_min <= hi_run;
      if (ps && scl_l && pd && !sda_l) begin
        n_start <= n_start + 1; sst <= SA; sbc <= 0; s_pull <= 1'b0;
      end else if (ps && scl_l && !pd && sda_l) begin
        n_stop <= n_stop + 1; sst <= SI; s_pull <= 1'b0;
      end else if (!ps && scl_l) begin
        if ((sst == SA || sst == SW) && sbc < 8) begin
          ssh <= {ssh[6:0], sda_l}; sbc <= sbc + 1;
        end else if (sst == SM) begin
          if (sda_l) n_mnack <= n_mnack + 1; else n_mack <= n_mack + 1;
          smack <= !sda_l;
        end
      end else if (ps && !scl_l) begin
        case (sst)
          SA: if (sbc == 8) begin
            if (ssh[7:1] == SADDR) begin s_pull <= 1'b1; srw <= ssh[0]; sst <= SAA; end
            else sst <= SG;
          end
          SW: if (sbc == 8) begin
            if (sfirst) sptr <= ssh[3:0];
            else begin smem[sptr] <= ssh; sptr <= sptr + 4'd1; end
            sfirst <= 1'b0; s_pull <= 1'b1; sst <= SAD;
          end
          SAA: if (srw) begin
            stxb <= smem[sptr]; s_pull <= !smem[sptr][7]; sbc <= 1; sst <= STX;
          end else begin
            s_pull <= 1'b0; sst <= SW; sbc <= 0; sfirst <= 1'b1;
          end
          SAD: begin s_pull <= 1'b0; sst <= SW; sbc <= 0; end
          STX: if (sbc < 8) begin
            s_pull <= !stxb[7 - sbc]; sbc <= sbc + 1;
          end else begin
            s_pull <= 1'b0; sst <= SM;
          end
          SM: if (smack) begin
            sptr <= sptr + 4'd1; stxb <= smem[sptr + 4'd1];
            s_pull <= !smem[sptr + 4'd1][7]; sbc <= 1; sst <= STX;
          end else begin
            s_pull <= 1'b0; sst <= SG;
          end
          default: ;
        endcase
      end
    end
  end

  int nchk = 0, nfail = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] v;
    bit ok = 0;
    for (int i = 0; i < 20000 && !ok; i++) begin
      rd(A_STS, v);
      if (v[27]) ok = 1;
    end
    chk(req, "done bit reached", 32'(ok), 32'd1);
  endtask

  task automatic clr_hi();
    @(negedge clk); hi_clr = 1'b1;
    @(negedge clk); hi_clr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1", "scl released", 32'(scl_pull), 32'd0);
    chk("R1", "sda released", 32'(sda_pull), 32'd0);
    chk("R1", "irq low", 32'(irq), 32'd0);
    rd(A_STS, v); chk("R1", "status", v, 32'h0);
    rd(A_CTL, v); chk("R1", "control", v, 32'h0);
    rd(A_REV, v); chk("R12", "revision", v, REV);
    rd(A_RX, v);  chk("R5", "empty rx flag", v, 32'h100);
  endtask

  task automatic t_write();
    int s0 = n_start, p0 = n_stop;
    logic [31:0] v;
    wr(A_CTL, C_EN | 32'd1);
    clr_hi();
    wr(A_TX, F_START | 32'hA0);
    wr(A_TX, 32'h03);
    wr(A_TX, 32'h5A);
    wr(A_TX, F_STOP | 32'hC3);
    wait_done("R7");
    chk("R2", "byte at 3", 32'(smem[3]), 32'h5A);
    chk("R3", "stop-flagged byte at 4", 32'(smem[4]), 32'hC3);
    chk("R2", "one start", 32'(n_start - s0), 32'd1);
    chk("R3", "one stop", 32'(n_stop - p0), 32'd1);
    chk("R10", "scl high width div=1", 32'(hi_min), 32'd8);
    rd(A_STS, v); chk("R8", "no nack", v & ST_NACK, 32'h0);
    wr(A_STS, ST_DONE);
    rd(A_STS, v); chk("R7", "done cleared by w1c", v, 32'h0);
  endtask

  task automatic t_read();
    int s0 = n_start, p0 = n_stop, a0 = n_mack, n0 = n_mnack;
    logic [31:0] v;
    wr(A_TX, F_START | 32'hA0);
    wr(A_TX, 32'h03);
    wr(A_TX, F_START | 32'hA1);
    wr(A_TX, F_READ | F_STOP | 32'd2);
    wait_done("R4");
    chk("R6", "repeated start count", 32'(n_start - s0), 32'd2);
    chk("R6", "single stop", 32'(n_stop - p0), 32'd1);
    chk("R4", "master acks", 32'(n_mack - a0), 32'd1);
    chk("R4", "master nacks last", 32'(n_mnack - n0), 32'd1);
    rd(A_RX, v); chk("R4", "first rx byte", v, 32'h5A);
    rd(A_RX, v); chk("R5", "second rx byte", v, 32'hC3);
    rd(A_RX, v); chk("R5", "rx empty after drain", v, 32'h100);
    wr(A_STS, ST_DONE);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(A_MSK, ST_DONE);
    chk("R9", "irq low before done", 32'(irq), 32'd0);
    wr(A_TX, F_START | 32'hA0);
    wr(A_TX, F_STOP | 32'h09);
    wait_done("R9");
    @(negedge clk);
    chk("R9", "irq on masked done", 32'(irq), 32'd1);
    wr(A_MSK, 32'h0);
    chk("R9", "irq off with zero mask", 32'(irq), 32'd0);
    rd(A_STS, v); chk("R9", "status kept", v, ST_DONE);
    wr(A_MSK, ST_DONE);
    chk("R9", "irq back with mask", 32'(irq), 32'd1);
    wr(A_STS, ST_DONE);
    chk("R9", "irq off after clear", 32'(irq), 32'd0);
    wr(A_MSK, 32'h0);
  endtask

  task automatic t_nack();
    int s0 = n_start, p0 = n_stop;
    logic [31:0] v;
    wr(A_TX, F_START | 32'h42);
    wr(A_TX, 32'h11);
    wr(A_TX, F_STOP | 32'h22);
    wr(A_TX, F_START | 32'hA0);
    wr(A_TX, 32'h07);
    wr(A_TX, F_STOP | 32'h99);
    wait_done("R8");
    rd(A_STS, v); chk("R8", "nack and done", v & (ST_NACK | ST_DONE), ST_NACK | ST_DONE);
    wr(A_STS, ST_NACK | ST_DONE);
    wait_done("R8");
    rd(A_STS, v); chk("R8", "next transfer clean", v & ST_NACK, 32'h0);
    chk("R8", "next transfer data", 32'(smem[7]), 32'h99);
    chk("R8", "starts", 32'(n_start - s0), 32'd2);
    chk("R8", "stops", 32'(n_stop - p0), 32'd2);
    wr(A_STS, ST_DONE);
  endtask

  task automatic t_enable();
    int s0 = n_start, moved = 0;
    logic [31:0] v;
    wr(A_CTL, 32'd1);
    wr(A_TX, F_START | 32'hA0);
    wr(A_TX, F_STOP | 32'h0A);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (scl_pull) moved++;
    end
    chk("R10", "bus idle while disabled", 32'(moved), 32'd0);
    wr(A_CTL, C_TXCLR | 32'd1);
    wr(A_CTL, C_EN | 32'd1);
    repeat (400) @(negedge clk);
    chk("R10", "flushed commands never run", 32'(n_start - s0), 32'd0);
    rd(A_STS, v); chk("R10", "no done after flush", v, 32'h0);
  endtask

  task automatic t_overflow();
    int p0 = n_stop;
    logic [31:0] v;
    wr(A_CTL, 32'd1);
    wr(A_TX, F_START | 32'hA0);
    wr(A_TX, 32'h08);
    for (int i = 0; i < 13; i++) wr(A_TX, 32'h30 + 32'(i));
    wr(A_TX, F_STOP | 32'h77);
    rd(A_STS, v); chk("R11", "no overflow at full", v, 32'h0);
    wr(A_TX, F_START | F_STOP | 32'h42);
    rd(A_STS, v); chk("R11", "overflow flag", v, ST_OVF);
    wr(A_CTL, C_EN | 32'd1);
    wait_done("R11");
    repeat (400) @(negedge clk);
    rd(A_STS, v); chk("R11", "dropped word not run", v & ST_NACK, 32'h0);
    chk("R11", "last queued byte", 32'(smem[5]), 32'h77);
    chk("R11", "one stop only", 32'(n_stop - p0), 32'd1);
    wr(A_STS, ST_OVF | ST_DONE);
    rd(A_STS, v); chk("R11", "overflow cleared", v, 32'h0);
  endtask

  task automatic t_rxflush();
    logic [31:0] v;
    wr(A_TX, F_START | 32'hA1);
    wr(A_TX, F_READ | F_STOP | 32'd2);
    wait_done("R10");
    rd(A_RX, v); chk("R5", "rx holds data", v & 32'h100, 32'h0);
    wr(A_CTL, C_RXCLR | C_EN | 32'd1);
    rd(A_RX, v); chk("R10", "rx flushed", v & 32'h100, 32'h100);
    wr(A_STS, ST_DONE);
  endtask

  task automatic t_divider();
    wr(A_CTL, C_EN | 32'd3);
    clr_hi();
    wr(A_TX, F_START | 32'hA0);
    wr(A_TX, F_STOP | 32'h0C);
    wait_done("R10");
    chk("R10", "scl high width div=3", 32'(hi_min), 32'd16);
    wr(A_STS, ST_DONE);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    fork
      begin
        t_reset();
        t_write();
        t_read();
        t_irq();
        t_nack();
        t_enable();
        t_overflow();
        t_rxflush();
        t_divider();
      end
      begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R7 watchdog: actual hung expected finished");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule